// File: doc/BRIEF.md
# Memory type range resolver

This block answers one question for the memory system: what caching behaviour applies to a given physical address. It holds a small configuration file: eleven 64-bit words of per-region type bytes that cover the first megabyte, a parameterised number of variable ranges (each a base word and a mask word), a control word with the fallback type and two enable bits, and an upper bound for an extra write-back window above 4 GiB. Software or a boot engine loads these words through a one-word-per-cycle write port.

A lookup presents an address with a valid strobe. One cycle later the block returns the resolved type and a flag. The flag is set when a low-memory entry, the extra window or at least one variable range supplied the type. It is clear when the fallback type was used or when the whole mechanism is switched off. Type codes are one byte: uncacheable 0x00, write-combining 0x01, write-through 0x04, write-protect 0x05, write-back 0x06.

Top module: `memtype_resolver`

## Requirements
- R1: `resp_valid` rises exactly one cycle after a cycle with `req_valid` high and is low otherwise; while reset is active `resp_valid`, `resp_type` and `resp_hit` are all 0.
- R2: Below 0x100000 the address selects one of 88 type bytes: eight 64 KiB slots from 0, sixteen 16 KiB slots from 0x80000, sixty-four 4 KiB slots from 0xC0000, numbered in that order. Slot k is byte k%8 (bits 8*(k%8)+7 down to 8*(k%8)) of table word k/8.
- R3: With the global enable and the low-memory enable both set, an address below 0x100000 returns its table byte with `resp_hit`=1 regardless of variable ranges; with the low-memory enable clear, such an address is resolved by variable ranges and the fallback type.
- R4: Variable range i takes part only when bit 11 of its mask word is set; it matches when address bits 47:12, masked by mask-word bits 47:12, equal base-word bits 47:12 masked the same way; its type is base-word bits 7:0.
- R5: Types of all matching variable ranges are combined pairwise: any uncacheable gives uncacheable; write-back with write-through gives write-through; any other unequal pair gives uncacheable; equal types keep that type.
- R6: An address matched by nothing returns the fallback type with `resp_hit`=0.
- R7: With the global enable clear, every lookup returns uncacheable (0x00) with `resp_hit`=0.
- R8: With a nonzero upper bound, addresses from 0x1_0000_0000 up to (but not including) the bound return write-back with `resp_hit`=1, overriding variable ranges; the stored bound keeps only bits 47:23 (8 MiB granularity); a zero bound disables the window.
- R9: Write select codes: 0 to 10 are the table words; 12 is the control word (bits 7:0 fallback type, bit 10 low-memory enable, bit 11 global enable); 13 is the window bound; 16+2i is the base word and 17+2i the mask word of variable range i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | SEL_W | Configuration word select |
| wr_data | input | 64 | Configuration write data |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | Physical address to resolve |
| resp_valid | output | 1 | Lookup result strobe |
| resp_type | output | 8 | Resolved memory type |
| resp_hit | output | 1 | A range or table entry supplied the type |

## Verification
The assertions take for granted that configuration words are not rewritten in the same cycle as a lookup whose answer they would change, since the properties relate the registered state seen at the request to the response that follows; the stimulus always lets a write settle for a full cycle before the next lookup. They also assume variable ranges carry only the five defined type codes, and the bench programmes only those codes. Requests are issued only after the internal reset release has completed, so the expected-valid tracking in the bench never overlaps the reset window.

// File: rtl/memtype_pkg.sv
package memtype_pkg;

  typedef logic [7:0] mtype_t;

  localparam mtype_t MT_UC   = 8'h00;
  localparam mtype_t MT_WC   = 8'h01;
  localparam mtype_t MT_WT   = 8'h04;
  localparam mtype_t MT_WP   = 8'h05;
  localparam mtype_t MT_WB   = 8'h06;
  localparam mtype_t MT_NONE = 8'hFF;

  localparam int DATA_W      = 64;
  localparam int FIX_REGS    = 11;
  localparam int FIX_ENTRIES = FIX_REGS * 8;
  localparam int PG_SHIFT    = 12;
  localparam int WIN_SHIFT   = 23;

  // Pairwise merge of two overlapping range types.
  function automatic mtype_t mt_combine(input mtype_t a, input mtype_t b);
    mtype_t r;
    if (a == MT_UC || b == MT_UC)
      r = MT_UC;
    else if ((a == MT_WB && b == MT_WT) || (a == MT_WT && b == MT_WB))
      r = MT_WT;
    else if (a != b)
      r = MT_UC;
    else
      r = a;
    return r;
  endfunction

endpackage

// File: rtl/mtr_cfg_regs.sv
module mtr_cfg_regs
  import memtype_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int NUM_VAR = 4,
  parameter int SEL_W   = 6
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic [SEL_W-1:0]                       wr_sel,
  input  logic [DATA_W-1:0]                      wr_data,
  output logic [FIX_REGS-1:0][DATA_W-1:0]        fix_q,
  output mtype_t                                 def_type_q,
  output logic                                   fix_en_q,
  output logic                                   glob_en_q,
  output logic [ADDR_W-1:WIN_SHIFT]              win_top_q,
  output logic [NUM_VAR-1:0][ADDR_W-PG_SHIFT-1:0] vbase_q,
  output logic [NUM_VAR-1:0][7:0]                vtype_q,
  output logic [NUM_VAR-1:0][ADDR_W-PG_SHIFT-1:0] vmask_q,
  output logic [NUM_VAR-1:0]                     vvld_q
);

  localparam int CTRL_SEL = 12;
  localparam int WIN_SEL  = 13;
  localparam int VAR_SEL0 = 16;
  localparam int FEN_BIT  = 10;
  localparam int GEN_BIT  = 11;
  localparam int VLD_BIT  = 11;

  logic [FIX_REGS-1:0] fix_we;
  logic                ctrl_we;
  logic                win_we;
  logic [NUM_VAR-1:0]  base_we;
  logic [NUM_VAR-1:0]  mask_we;

  // Write strobe decode (next-state side).
  always_comb begin
    ctrl_we = wr_en && (wr_sel == SEL_W'(CTRL_SEL));
    win_we  = wr_en && (wr_sel == SEL_W'(WIN_SEL));
  end

  for (genvar r = 0; r < FIX_REGS; r++) begin : g_fix
    always_comb fix_we[r] = wr_en && (wr_sel == SEL_W'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         fix_q[r] <= '0;
      else if (fix_we[r]) fix_q[r] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      def_type_q <= MT_UC;
      fix_en_q   <= 1'b0;
      glob_en_q  <= 1'b0;
    end else if (ctrl_we) begin
      def_type_q <= wr_data[7:0];
      fix_en_q   <= wr_data[FEN_BIT];
      glob_en_q  <= wr_data[GEN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_top_q <= '0;
    else if (win_we) win_top_q <= wr_data[ADDR_W-1:WIN_SHIFT];
  end

  for (genvar i = 0; i < NUM_VAR; i++) begin : g_var
    always_comb begin
      base_we[i] = wr_en && (wr_sel == SEL_W'(VAR_SEL0 + 2*i));
      mask_we[i] = wr_en && (wr_sel == SEL_W'(VAR_SEL0 + 2*i + 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vbase_q[i] <= '0;
        vtype_q[i] <= '0;
      end else if (base_we[i]) begin
        vbase_q[i] <= wr_data[ADDR_W-1:PG_SHIFT];
        vtype_q[i] <= wr_data[7:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vmask_q[i] <= '0;
        vvld_q[i]  <= 1'b0;
      end else if (mask_we[i]) begin
        vmask_q[i] <= wr_data[ADDR_W-1:PG_SHIFT];
        vvld_q[i]  <= wr_data[VLD_BIT];
      end
    end
  end

  // R9: a write to the control word lands in the control fields next cycle
  a_r9_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (def_type_q == $past(wr_data[7:0])) && (glob_en_q == $past(wr_data[GEN_BIT])));

endmodule

// File: rtl/mtr_fixed_lookup.sv
module mtr_fixed_lookup
  import memtype_pkg::*;
(
  input  logic [7:0]                      addr_pg,   // address bits 19:12
  input  logic [FIX_REGS-1:0][DATA_W-1:0] fix_q,
  output mtype_t                          fix_type
);

  localparam int IDX_W   = $clog2(FIX_ENTRIES);
  localparam int BASE_16 = 8;
  localparam int BASE_4  = 24;

  logic [IDX_W-1:0] idx;
  logic [IDX_W-4:0] word_n;
  logic [2:0]       byte_n;

  // Slot number: 64 KiB slots, then 16 KiB slots, then 4 KiB slots.
  always_comb begin
    if (!addr_pg[7])
      idx = IDX_W'(addr_pg[6:4]);
    else if (!addr_pg[6])
      idx = IDX_W'(BASE_16) + IDX_W'(addr_pg[5:2]);
    else
      idx = IDX_W'(BASE_4) + IDX_W'(addr_pg[5:0]);
  end

  always_comb begin
    word_n   = idx[IDX_W-1:3];
    byte_n   = idx[2:0];
    fix_type = fix_q[word_n][{byte_n, 3'b000} +: 8];
  end

endmodule

// File: rtl/mtr_var_merge.sv
module mtr_var_merge
  import memtype_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int NUM_VAR = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [ADDR_W-PG_SHIFT-1:0]             addr_pg,
  input  logic [NUM_VAR-1:0][ADDR_W-PG_SHIFT-1:0] vbase_q,
  input  logic [NUM_VAR-1:0][7:0]                vtype_q,
  input  logic [NUM_VAR-1:0][ADDR_W-PG_SHIFT-1:0] vmask_q,
  input  logic [NUM_VAR-1:0]                     vvld_q,
  output mtype_t                                 var_type
);

  logic [NUM_VAR-1:0] match;
  logic [NUM_VAR-1:0] match_uc;

  for (genvar i = 0; i < NUM_VAR; i++) begin : g_match
    always_comb begin
      match[i]    = vvld_q[i] && (((addr_pg ^ vbase_q[i]) & vmask_q[i]) == '0);
      match_uc[i] = match[i] && (vtype_q[i] == MT_UC);
    end
  end

  // Fold matching types; MT_NONE means nothing has matched yet.
  always_comb begin
    var_type = MT_NONE;
    for (int i = 0; i < NUM_VAR; i++) begin
      if (match[i]) begin
        if (var_type == MT_NONE) var_type = vtype_q[i];
        else                     var_type = mt_combine(var_type, vtype_q[i]);
      end
    end
  end

  // R5: one uncacheable participant forces uncacheable
  a_r5_uc_dominates: assert property (@(posedge clk) disable iff (!rst_n)
    (|match_uc) |-> (var_type == MT_UC));

  // R4: without a valid match the fold stays empty
  a_r4_empty_without_match: assert property (@(posedge clk) disable iff (!rst_n)
    (match == '0) |-> (var_type == MT_NONE));

endmodule

// File: rtl/memtype_resolver.sv
module memtype_resolver
  import memtype_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int NUM_VAR = 4,
  parameter int SEL_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  output logic [7:0]        resp_type,
  output logic              resp_hit
);

  localparam int PA_W   = ADDR_W - PG_SHIFT;
  localparam int LOW_MB = 20;
  localparam int HI4G   = 32;

  // Reset: asserted at once, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [FIX_REGS-1:0][DATA_W-1:0] fix_q;
  mtype_t                          def_type_q;
  logic                            fix_en_q;
  logic                            glob_en_q;
  logic [ADDR_W-1:WIN_SHIFT]       win_top_q;
  logic [NUM_VAR-1:0][PA_W-1:0]    vbase_q;
  logic [NUM_VAR-1:0][7:0]         vtype_q;
  logic [NUM_VAR-1:0][PA_W-1:0]    vmask_q;
  logic [NUM_VAR-1:0]              vvld_q;

  mtr_cfg_regs #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR), .SEL_W(SEL_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .fix_q      (fix_q),
    .def_type_q (def_type_q),
    .fix_en_q   (fix_en_q),
    .glob_en_q  (glob_en_q),
    .win_top_q  (win_top_q),
    .vbase_q    (vbase_q),
    .vtype_q    (vtype_q),
    .vmask_q    (vmask_q),
    .vvld_q     (vvld_q)
  );

  mtype_t fix_type;
  mtype_t var_type;

  mtr_fixed_lookup u_fixed (
    .addr_pg  (req_addr[LOW_MB-1:PG_SHIFT]),
    .fix_q    (fix_q),
    .fix_type (fix_type)
  );

  mtr_var_merge #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR)) u_var (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .addr_pg  (req_addr[ADDR_W-1:PG_SHIFT]),
    .vbase_q  (vbase_q),
    .vtype_q  (vtype_q),
    .vmask_q  (vmask_q),
    .vvld_q   (vvld_q),
    .var_type (var_type)
  );

  logic   below_1m;
  logic   in_window;
  mtype_t res_type;
  logic   res_hit;

  always_comb begin
    below_1m  = (req_addr[ADDR_W-1:LOW_MB] == '0);
    in_window = (win_top_q != '0) && (req_addr[ADDR_W-1:HI4G] != '0) &&
                (req_addr < {win_top_q, {WIN_SHIFT{1'b0}}});
  end

  // Priority: global off, low-memory table, window, variable, fallback.
  always_comb begin
    res_type = def_type_q;
    res_hit  = 1'b0;
    if (!glob_en_q) begin
      res_type = MT_UC;
      res_hit  = 1'b0;
    end else if (fix_en_q && below_1m) begin
      res_type = fix_type;
      res_hit  = 1'b1;
    end else if (in_window) begin
      res_type = MT_WB;
      res_hit  = 1'b1;
    end else if (var_type != MT_NONE) begin
      res_type = var_type;
      res_hit  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) resp_valid <= 1'b0;
    else            resp_valid <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      resp_type <= MT_UC;
      resp_hit  <= 1'b0;
    end else if (req_valid) begin
      resp_type <= res_type;
      resp_hit  <= res_hit;
    end
  end

  // R1: response strobe tracks the request one cycle later
  a_r1_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n_int)
    req_valid |=> resp_valid);
  a_r1_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n_int)
    !req_valid |=> !resp_valid);

  // R7: global disable gives uncacheable with no hit
  a_r7_disabled_uc: assert property (@(posedge clk) disable iff (!rst_n_int)
    (req_valid && !glob_en_q) |=> (resp_type == MT_UC) && !resp_hit);

  // R3: enabled low-memory table always reports a hit
  a_r3_low_table_hit: assert property (@(posedge clk) disable iff (!rst_n_int)
    (req_valid && glob_en_q && fix_en_q && req_addr < ADDR_W'(1 << LOW_MB)) |=> resp_hit);

  // R8: window above 4 GiB resolves to write-back
  a_r8_window_wb: assert property (@(posedge clk) disable iff (!rst_n_int)
    (req_valid && glob_en_q && win_top_q != '0 && req_addr[ADDR_W-1:HI4G] != '0 &&
     req_addr < {win_top_q, {WIN_SHIFT{1'b0}}}) |=> (resp_type == MT_WB) && resp_hit);

endmodule

// File: tb/memtype_resolver_tb.sv
module memtype_resolver_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 48;
  localparam int NV = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [5:0]    wr_sel = '0;
  logic [63:0]   wr_data = '0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          resp_valid;
  logic [7:0]    resp_type;
  logic          resp_hit;

  always #(CLK_PERIOD/2) clk = ~clk;

  memtype_resolver #(.ADDR_W(AW), .NUM_VAR(NV), .SEL_W(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .req_valid(req_valid), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_type(resp_type), .resp_hit(resp_hit)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Shadow configuration, kept by the bench from its own writes.
  logic [7:0]    fx [88];
  logic [AW-1:0] vb [NV];
  logic [7:0]    vt [NV];
  logic [AW-1:0] vm [NV];
  logic          vv [NV];
  logic [7:0]    deft = 8'h00;
  logic          fen = 1'b0;
  logic          gen = 1'b0;
  logic [AW-1:0] t2 = '0;

  // Scoreboard queues.
  logic [7:0] q_type [$];
  logic       q_hit  [$];
  string      q_tag  [$];
  logic [AW-1:0] q_addr [$];
  logic       exp_v = 1'b0;

  function automatic logic [7:0] merge2(input logic [7:0] a, input logic [7:0] b);
    if (a == 8'h00 || b == 8'h00) return 8'h00;
    if (a == b) return a;
    if ((a | b) == 8'h06 && a != b && (a == 8'h04 || b == 8'h04)) return 8'h04;
    return 8'h00;
  endfunction

  function automatic logic [8:0] model(input logic [AW-1:0] a);
    logic [7:0] acc;
    int k;
    logic [AW-1:0] lim;
    if (!gen) return {1'b0, 8'h00};
    if (fen && a < 48'h10_0000) begin
      if (a < 48'h8_0000)      k = int'(a / 48'h1_0000);
      else if (a < 48'hC_0000) k = 8 + int'((a - 48'h8_0000) / 48'h4000);
      else                     k = 24 + int'((a - 48'hC_0000) / 48'h1000);
      return {1'b1, fx[k]};
    end
    lim = t2 & ~48'h7F_FFFF;
    if (lim != 0 && a >= 48'h1_0000_0000 && a < lim) return {1'b1, 8'h06};
    acc = 8'hFF;
    for (int i = 0; i < NV; i++) begin
      if (vv[i] && (((a ^ vb[i]) & vm[i] & ~48'hFFF) == 0))
        acc = (acc == 8'hFF) ? vt[i] : merge2(acc, vt[i]);
    end
    if (acc != 8'hFF) return {1'b1, acc};
    return {1'b0, deft};
  endfunction

  task automatic wr(input logic [5:0] s, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [7:0] t, input logic f, input logic g);
    deft = t; fen = f; gen = g;
    wr(6'd12, {52'd0, g, f, 2'b00, t});
  endtask

  task automatic wr_var(input int i, input logic [AW-1:0] base, input logic [7:0] t,
                        input logic [AW-1:0] size, input logic valid);
    logic [AW-1:0] m;
    m = ~(size - 1) & ~48'hFFF;
    vb[i] = base; vt[i] = t; vm[i] = m; vv[i] = valid;
    wr(6'(16 + 2*i), {16'd0, base & ~48'hFFF} | {56'd0, t});
    wr(6'(17 + 2*i), {16'd0, m} | (valid ? 64'h800 : 64'h0));
  endtask

  task automatic look(input logic [AW-1:0] a, input string tag);
    logic [8:0] e;
    @(negedge clk);
    e = model(a);
    req_valid = 1'b1; req_addr = a;
    q_type.push_back(e[7:0]); q_hit.push_back(e[8]);
    q_tag.push_back(tag); q_addr.push_back(a);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  always @(posedge clk) exp_v <= req_valid;

  // Monitor: compares each response with the oldest expected item.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (resp_valid !== exp_v) begin
        checks++; errors++;
        $display("FAIL R1 resp_valid actual=%0b expected=%0b", resp_valid, exp_v);
      end
      if (resp_valid === 1'b1 && q_type.size() > 0) begin
        logic [7:0] et; logic eh; string tg; logic [AW-1:0] ea;
        et = q_type.pop_front(); eh = q_hit.pop_front();
        tg = q_tag.pop_front();  ea = q_addr.pop_front();
        checks++;
        if (resp_type !== et || resp_hit !== eh) begin
          errors++;
          $display("FAIL %s addr=%h actual type=%h hit=%0b expected type=%h hit=%0b",
                   tg, ea, resp_type, resp_hit, et, eh);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 88; i++) fx[i] = 8'h00;
    for (int i = 0; i < NV; i++) begin vb[i] = '0; vt[i] = '0; vm[i] = '0; vv[i] = 1'b0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (resp_valid !== 1'b0 || resp_type !== 8'h00 || resp_hit !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual v=%0b t=%h h=%0b expected 0 00 0", resp_valid, resp_type, resp_hit);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9: control word, fallback write-protect, both enables on
    wr_ctrl(8'h05, 1'b1, 1'b1);
    // R2: fill the table words with a rotating type pattern
    for (int r = 0; r < 11; r++) begin
      logic [63:0] d;
      for (int b = 0; b < 8; b++) begin
        logic [7:0] t;
        case ((r * 8 + b + r) % 5)
          0: t = 8'h00; 1: t = 8'h01; 2: t = 8'h04; 3: t = 8'h05; default: t = 8'h06;
        endcase
        d[b*8 +: 8] = t;
        fx[r*8 + b] = t;
      end
      wr(6'(r), d);
    end
    look(48'h0_0000, "R2 first 64K slot");
    look(48'h3_0000, "R2 64K slot");
    look(48'h9_4000, "R2 16K slot");
    look(48'hB_F000, "R2 last 16K slot");
    look(48'hE_5000, "R2 4K slot");
    look(48'hF_F000, "R2 last 4K slot");

    // Variable ranges (R4, R5)
    wr_var(0, 48'h0,         8'h06, 48'h1000_0000, 1'b1); // WB 0..256M
    wr_var(1, 48'h100_0000,  8'h00, 48'h10_0000,   1'b1); // UC
    wr_var(2, 48'h200_0000,  8'h04, 48'h10_0000,   1'b1); // WT
    wr_var(3, 48'h300_0000,  8'h01, 48'h10_0000,   1'b1); // WC
    look(48'h3_0000,     "R3 table beats variable");
    look(48'h500_0000,   "R4 single variable match");
    look(48'h100_0800,   "R5 UC with WB");
    look(48'h200_0000,   "R5 WB with WT");
    look(48'h30F_F000,   "R5 WB with WC");
    look(48'h2000_0000,  "R6 fallback");
    look(48'h1000_0000,  "R6 just past range");
    wr_var(3, 48'h400_0000, 8'h06, 48'h10_0000, 1'b1);
    look(48'h400_0000,   "R5 equal types");
    wr_var(1, 48'h100_0000, 8'h00, 48'h10_0000, 1'b0);
    look(48'h100_0000,   "R4 invalid range ignored");

    // R3: low-memory enable off
    wr_ctrl(8'h05, 1'b0, 1'b1);
    look(48'h3_0000,     "R3 table disabled");
    wr_ctrl(8'h05, 1'b1, 1'b1);

    // R8: window
    t2 = 48'h1_2345_6789;
    wr(6'd13, 64'h1_2345_6789);
    look(48'h1_22FF_F000, "R8 inside window");
    look(48'h1_2300_0000, "R8 truncated bound");
    look(48'h0_FFFF_F000, "R8 below 4G");
    wr_var(2, 48'h1_0000_0000, 8'h00, 48'h100_0000, 1'b1);
    look(48'h1_0000_0000, "R8 window beats variable");
    t2 = '0;
    wr(6'd13, 64'h0);
    look(48'h1_0000_0000, "R8 zero bound");

    // R7: global disable
    wr_ctrl(8'h05, 1'b1, 1'b0);
    look(48'h3_0000,     "R7 disabled low");
    look(48'h500_0000,   "R7 disabled var");
    look(48'h2000_0000,  "R7 disabled fallback");

    repeat (4) @(negedge clk);
    if (q_type.size() != 0) begin
      checks++; errors++;
      $display("FAIL R1 missing responses actual=%0d expected=0", q_type.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule